// File: doc/BRIEF.md
# Serial Port Core with Line Echo

The block is a full-duplex asynchronous serial transceiver that a host drives through a small byte-wide register port: a select, one address bit, and single-cycle read and write strobes. Both directions share one oversampling tick at sixteen times the bit rate. A selectable prescaler, followed by a programmable divider, produces that tick. The tick stays off until the host writes the mode register for the first time. Characters are 8 data bits, an optional even or odd parity bit, and one stop bit.

On the transmit side, a holding register feeds a shift register, and a clear-to-send input gates the start of each frame. On the receive side, the block hunts for a start edge, samples each bit at mid-bit, and checks parity, framing, overrun and break. An 8-bit status register reports these results together with the transmitter state and changes on the modem inputs. In echo mode, the serial input is routed combinationally to the serial output, and writes to the transmit register are discarded.

Register map: address 0 is the receive buffer on read and the transmit holding register on write. Address 1 is the status register on read. A write to address 1 with bit 7 = 0 loads the mode register: bits [1:0] prescaler select, bit 2 echo, bit 3 parity enable, bit 4 odd parity, bit 5 request-to-send output, bit 6 terminal-ready output. A write to address 1 with bit 7 = 1 loads bits [6:0] as the divider value N, which divides by N+1.

Top module: `serial_port_core`

## Requirements
- R1: After reset the status register reads 0x60, `sdo` is 1, `rts` and `dtr` are 0, `intr` is 0, and `baud_tick` never pulses until the first mode write.
- R2: The tick period in clocks is the prescale ratio times (N+1). The prescale ratio is 1, 3, 4 or 2 for select codes 0, 1, 2 and 3.
- R3: A transmitted frame consists of a 0 start bit, the data LSB first, a parity bit if enabled (even: XOR of the data; odd: its inverse), and a 1 stop bit. Each bit lasts 16 ticks, and `sdo` idles at 1.
- R4: Status bit 6 (holding empty) clears when address 0 is written. If the shifter is idle, the byte moves into the shifter on the 4th tick after the write, and bit 6 sets again. Status bit 5 (transmission complete) is 1 only when both the holding register and the shifter are empty.
- R5: In echo mode `sdo` equals `sdi`, and a write to address 0 changes nothing; status bit 6 stays 1.
- R6: The receiver starts on a 1-to-0 edge of `sdi` and samples 8 ticks later, then every 16 ticks. It places the data byte in the receive buffer.
- R7: A start bit that is 1 at its mid-bit sample is discarded. No character is produced, and the receiver resumes hunting.
- R8: Status bit 7 (data ready) sets in the 11th tick period of the stop bit. A read of address 0 clears it.
- R9: Status bit 0 flags a parity mismatch, and status bit 1 flags a stop bit sampled 0.
- R10: Status bit 2 (overrun) sets when a character completes while bit 7 is still set. The newer byte replaces the buffer contents.
- R11: Status bit 3 (break) sets when every sampled position of a character is 0.
- R12: A read of address 1 clears status bits 0 to 4 and leaves bits 5 to 7 unchanged.
- R13: Status bit 4 sets on any change of the synchronized `cts` or `dsr`. `intr` is the OR of status bits 0, 1, 2, 3, 4 and 7. `rts` and `dtr` follow mode bits 5 and 6.
- R14: While `cts` is 0 no frame starts. The byte stays in the holding register and status bit 6 stays 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sel | input | 1 | Register port select |
| addr | input | 1 | Register address |
| wr_stb | input | 1 | Write strobe, one cycle |
| rd_stb | input | 1 | Read strobe, one cycle; clears flags on the following edge |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for the current address |
| sdi | input | 1 | Serial input |
| sdo | output | 1 | Serial output |
| cts | input | 1 | Clear-to-send; a frame may start while it is 1 |
| dsr | input | 1 | Data-set-ready modem input |
| rts | output | 1 | Request-to-send modem output |
| dtr | output | 1 | Terminal-ready modem output |
| intr | output | 1 | Interrupt request |
| baud_tick | output | 1 | One-clock pulse per oversampling period |

## Verification
The properties assume that the strobes are single-cycle pulses qualified by `sel` and that the serial and modem inputs settle between clock edges. They also assume the host does not read status in the same cycle that a character completes, because the set of a flag would then hide the clear. The bench drives every input at the falling clock edge and holds each serial bit for a whole number of ticks. It reads status only once the line has gone quiet after a frame, so the flag-clearing property always sees a cycle free of new events.

// File: rtl/sp_pkg.sv
`timescale 1ns/1ps
// Shared constants and types for the serial port core.
// Assumes a fixed 8-bit character and 16x oversampling.
package sp_pkg;
    localparam int DATA_W     = 8;
    localparam int OVS        = 16;
    localparam int OVS_W      = $clog2(OVS);
    localparam int MID_TICK   = OVS / 2 - 1;   // 8th tick period of a bit
    localparam int DONE_TICK  = 10;            // 11th tick period of the stop bit
    localparam int LOAD_TICKS = 4;             // ticks from write to shifter load

    // Status bit positions (host software decodes these)
    localparam int ST_PE   = 0;
    localparam int ST_FE   = 1;
    localparam int ST_OE   = 2;
    localparam int ST_BRK  = 3;
    localparam int ST_MS   = 4;
    localparam int ST_TC   = 5;
    localparam int ST_TBRE = 6;
    localparam int ST_DR   = 7;

    typedef struct packed {
        logic       dtr;
        logic       rts;
        logic       odd;
        logic       par_en;
        logic       echo;
        logic [1:0] pre_sel;
    } mode_t;

    // Prescale ratio for each select code
    function automatic logic [2:0] pre_ratio(input logic [1:0] sel);
        case (sel)
            2'd0:    return 3'd1;
            2'd1:    return 3'd3;
            2'd2:    return 3'd4;
            default: return 3'd2;
        endcase
    endfunction
endpackage

// File: rtl/sp_sync.sv
`timescale 1ns/1ps
// Multi-bit, multi-stage synchronizer for asynchronous inputs.
// Assumes the inputs idle high, so every stage resets to 1.
module sp_sync #(
    parameter int WIDTH  = 3,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [WIDTH-1:0] stage [STAGES];

    genvar gi;
    generate
        for (gi = 0; gi < STAGES; gi++) begin : g_stage
            // Shift one stage of the synchronizer chain
            always_ff @(posedge clk) begin
                if (!rst_n)
                    stage[gi] <= '1;
                else if (gi == 0)
                    stage[gi] <= d;
                else
                    stage[gi] <= stage[(gi == 0) ? 0 : gi - 1];
            end
        end
    endgenerate

    assign q = stage[STAGES-1];
endmodule

// File: rtl/sp_baud_gen.sv
`timescale 1ns/1ps
// Oversampling tick generator: prescaler then divide-by-(N+1).
// Assumes 'run' stays low until the mode has been programmed.
module sp_baud_gen import sp_pkg::*; #(
    parameter int DIV_W = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [1:0]       pre_sel,
    input  logic [DIV_W-1:0] div,
    output logic             tick
);
    logic [2:0]       pre_cnt;
    logic [DIV_W-1:0] div_cnt;
    logic             pre_hit;

    assign pre_hit = (pre_cnt >= pre_ratio(pre_sel) - 3'd1);

    // Count prescaler and divider; emit one-clock tick at divider wrap
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            pre_cnt <= '0;
            div_cnt <= '0;
            tick    <= 1'b0;
        end else begin
            pre_cnt <= pre_hit ? 3'd0 : pre_cnt + 3'd1;
            if (pre_hit)
                div_cnt <= (div_cnt >= div) ? '0 : div_cnt + 1'b1;
            tick <= pre_hit && (div_cnt >= div);
        end
    end
endmodule

// File: rtl/sp_tx.sv
`timescale 1ns/1ps
// Transmitter: holding register, settle counter and frame shifter.
// Assumes 'load' is a single-cycle pulse and 'cts' is synchronized.
module sp_tx import sp_pkg::*; (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              load,
    input  logic [DATA_W-1:0] data,
    input  logic              par_en,
    input  logic              odd,
    input  logic              cts,
    output logic              line,
    output logic              hold_empty,
    output logic              busy
);
    localparam int FRM_W = DATA_W + 2;
    localparam int CNT_W = $clog2(FRM_W + 1);
    localparam logic [OVS_W-1:0] SUB_LAST = OVS_W'(OVS - 1);
    localparam logic [2:0]       SETTLE_GO = 3'(LOAD_TICKS - 1);
    localparam logic [2:0]       SETTLE_MAX = 3'(LOAD_TICKS);

    logic [DATA_W-1:0] hold;
    logic              hold_full;
    logic [2:0]        settle;
    logic [FRM_W-1:0]  frm;
    logic [CNT_W-1:0]  left;
    logic [OVS_W-1:0]  sub;
    logic              start_ok;

    assign start_ok   = tick && hold_full && !busy && cts && (settle >= SETTLE_GO);
    assign hold_empty = !hold_full;

    // Holding register and the tick count since the last write
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold      <= '0;
            hold_full <= 1'b0;
            settle    <= '0;
        end else if (load) begin
            hold      <= data;
            hold_full <= 1'b1;
            settle    <= '0;
        end else if (start_ok) begin
            hold_full <= 1'b0;
        end else if (tick && hold_full && settle < SETTLE_MAX) begin
            settle <= settle + 3'd1;
        end
    end

    // Frame shifter: start bit, data LSB first, parity, stop
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            frm  <= '1;
            left <= '0;
            sub  <= '0;
            busy <= 1'b0;
            line <= 1'b1;
        end else if (start_ok && !load) begin
            frm  <= par_en ? {1'b1, (^hold) ^ odd, hold} : {2'b11, hold};
            left <= par_en ? CNT_W'(FRM_W) : CNT_W'(FRM_W - 1);
            sub  <= '0;
            busy <= 1'b1;
            line <= 1'b0;
        end else if (busy && tick) begin
            sub <= sub + 1'b1;
            if (sub == SUB_LAST) begin
                if (left == '0) begin
                    busy <= 1'b0;
                    line <= 1'b1;
                end else begin
                    line <= frm[0];
                    frm  <= {1'b1, frm[FRM_W-1:1]};
                    left <= left - 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/sp_rx.sv
`timescale 1ns/1ps
// Receiver: start-edge hunt, mid-bit sampling, error evaluation.
// Assumes 'line' is already synchronized to clk.
module sp_rx import sp_pkg::*; (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              line,
    input  logic              par_en,
    input  logic              odd,
    output logic              done,
    output logic [DATA_W-1:0] data,
    output logic              pe,
    output logic              fe,
    output logic              brk
);
    localparam logic [OVS_W-1:0] SUB_MID  = OVS_W'(MID_TICK);
    localparam logic [OVS_W-1:0] SUB_LAST = OVS_W'(OVS - 1);
    localparam logic [OVS_W-1:0] SUB_DONE = OVS_W'(DONE_TICK);

    logic             prev, active, par_s, stop_s, any_one;
    logic [OVS_W-1:0] sub;
    logic [3:0]       idx, stop_idx;

    assign stop_idx = par_en ? 4'(DATA_W + 2) : 4'(DATA_W + 1);

    // Track line, sample bits, and report a completed character
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev <= 1'b1;  active <= 1'b0;  sub <= '0;  idx <= '0;
            data <= '0;  par_s <= 1'b0;  stop_s <= 1'b1;  any_one <= 1'b0;
            done <= 1'b0;  pe <= 1'b0;  fe <= 1'b0;  brk <= 1'b0;
        end else begin
            prev <= line;
            done <= 1'b0;
            if (!active) begin
                if (prev && !line) begin
                    active  <= 1'b1;
                    sub     <= '0;
                    idx     <= '0;
                    any_one <= 1'b0;
                end
            end else if (tick) begin
                sub <= sub + 1'b1;
                if (sub == SUB_MID) begin
                    if (idx == 4'd0) begin
                        if (line) active <= 1'b0;
                    end else begin
                        any_one <= any_one | line;
                        if (idx <= 4'(DATA_W))
                            data <= {line, data[DATA_W-1:1]};
                        else if (idx == stop_idx)
                            stop_s <= line;
                        else
                            par_s <= line;
                    end
                end
                if (sub == SUB_LAST)
                    idx <= idx + 4'd1;
                if (idx == stop_idx && sub == SUB_DONE) begin
                    active <= 1'b0;
                    done   <= 1'b1;
                    fe     <= !stop_s;
                    pe     <= par_en && (par_s != ((^data) ^ odd));
                    brk    <= !any_one;
                end
            end
        end
    end
endmodule

// File: rtl/serial_port_core.sv
`timescale 1ns/1ps
// Serial port core top: register port, status flags, echo routing.
// Assumes single-cycle strobes qualified by sel; rdata is combinational.
module serial_port_core import sp_pkg::*; #(
    parameter int DIV_W       = 7,
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sel,
    input  logic       addr,
    input  logic       wr_stb,
    input  logic       rd_stb,
    input  logic [7:0] wdata,
    output logic [7:0] rdata,
    input  logic       sdi,
    output logic       sdo,
    input  logic       cts,
    input  logic       dsr,
    output logic       rts,
    output logic       dtr,
    output logic       intr,
    output logic       baud_tick
);
    mode_t             mode_q;
    logic [DIV_W-1:0]  div_q;
    logic              cfg_q;
    logic [2:0]        sync_q;
    logic              sdi_s, cts_s, dsr_s, cts_d, dsr_d, ms_evt;
    logic              tx_line, tx_hold_empty, tx_busy, tx_load;
    logic              rx_done, rx_pe, rx_fe, rx_brk;
    logic [DATA_W-1:0] rx_data, rx_buf;
    logic              dr_q, pe_q, fe_q, oe_q, brk_q, ms_q;
    logic              rd_data, rd_stat;
    logic [7:0]        status_w;

    assign rd_data = sel && rd_stb && !addr;
    assign rd_stat = sel && rd_stb && addr;
    assign tx_load = sel && wr_stb && !addr && !mode_q.echo;

    sp_sync #(.WIDTH(3), .STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .d({sdi, cts, dsr}), .q(sync_q)
    );
    assign {sdi_s, cts_s, dsr_s} = sync_q;

    // Mode and divider registers written through address 1
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= '0;
            div_q  <= '0;
            cfg_q  <= 1'b0;
        end else if (sel && wr_stb && addr) begin
            if (wdata[7]) begin
                div_q <= wdata[DIV_W-1:0];
            end else begin
                mode_q <= mode_t'(wdata[6:0]);
                cfg_q  <= 1'b1;
            end
        end
    end

    sp_baud_gen #(.DIV_W(DIV_W)) u_baud (
        .clk(clk), .rst_n(rst_n), .run(cfg_q), .pre_sel(mode_q.pre_sel),
        .div(div_q), .tick(baud_tick)
    );

    sp_tx u_tx (
        .clk(clk), .rst_n(rst_n), .tick(baud_tick), .load(tx_load),
        .data(wdata), .par_en(mode_q.par_en), .odd(mode_q.odd), .cts(cts_s),
        .line(tx_line), .hold_empty(tx_hold_empty), .busy(tx_busy)
    );

    sp_rx u_rx (
        .clk(clk), .rst_n(rst_n), .tick(baud_tick), .line(sdi_s),
        .par_en(mode_q.par_en), .odd(mode_q.odd), .done(rx_done),
        .data(rx_data), .pe(rx_pe), .fe(rx_fe), .brk(rx_brk)
    );

    assign ms_evt = (cts_s != cts_d) || (dsr_s != dsr_d);

    // Status flags: clears from reads, sets from events (sets win)
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dr_q <= 1'b0; pe_q <= 1'b0; fe_q <= 1'b0; oe_q <= 1'b0;
            brk_q <= 1'b0; ms_q <= 1'b0; rx_buf <= '0;
            cts_d <= 1'b1; dsr_d <= 1'b1;
        end else begin
            cts_d <= cts_s;
            dsr_d <= dsr_s;
            if (rd_data) dr_q <= 1'b0;
            if (rd_stat) begin
                pe_q <= 1'b0; fe_q <= 1'b0; oe_q <= 1'b0;
                brk_q <= 1'b0; ms_q <= 1'b0;
            end
            if (ms_evt) ms_q <= 1'b1;
            if (rx_done) begin
                rx_buf <= rx_data;
                dr_q   <= 1'b1;
                if (dr_q && !rd_data) oe_q <= 1'b1;
                if (rx_pe)  pe_q  <= 1'b1;
                if (rx_fe)  fe_q  <= 1'b1;
                if (rx_brk) brk_q <= 1'b1;
            end
        end
    end

    // Assemble the status byte at its fixed bit positions
    always_comb begin
        status_w           = '0;
        status_w[ST_PE]    = pe_q;
        status_w[ST_FE]    = fe_q;
        status_w[ST_OE]    = oe_q;
        status_w[ST_BRK]   = brk_q;
        status_w[ST_MS]    = ms_q;
        status_w[ST_TC]    = tx_hold_empty && !tx_busy;
        status_w[ST_TBRE]  = tx_hold_empty;
        status_w[ST_DR]    = dr_q;
    end

    assign rdata = addr ? status_w : rx_buf;
    assign sdo   = mode_q.echo ? sdi : tx_line;
    assign rts   = mode_q.rts;
    assign dtr   = mode_q.dtr;
    assign intr  = dr_q | pe_q | fe_q | oe_q | brk_q | ms_q;
endmodule

// File: rtl/sp_core_chk.sv
`timescale 1ns/1ps
// Protocol checker for serial_port_core, attached by bind.
// Assumes strobes are single-cycle and qualified by sel.
module sp_core_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       sel,
    input logic       addr,
    input logic       wr_stb,
    input logic       rd_stb,
    input logic       echo,
    input logic       baud_tick,
    input logic       rx_done,
    input logic       ms_evt,
    input logic       tx_busy,
    input logic       sdo,
    input logic [7:0] status
);
    // R4
    tbre_fall_on_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(status[6]) |-> $past(sel && wr_stb && !addr));

    // R5
    echo_ignores_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (echo && sel && wr_stb && !addr) |=> !$fell(status[6]));

    // R8
    dr_from_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(status[7]) |-> $past(rx_done));

    // R8
    done_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_done |-> $past(baud_tick));

    // R10
    overrun_needs_dr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(status[2]) |-> $past(status[7]));

    // R12
    status_read_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sel && rd_stb && addr && !rx_done && !ms_evt) |=> (status[4:0] == 5'd0));

    // R3
    start_from_shifter_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!echo && $fell(sdo)) |-> tx_busy);
endmodule

bind serial_port_core sp_core_chk u_chk (
    .clk(clk), .rst_n(rst_n), .sel(sel), .addr(addr), .wr_stb(wr_stb),
    .rd_stb(rd_stb), .echo(mode_q.echo), .baud_tick(baud_tick),
    .rx_done(rx_done), .ms_evt(ms_evt), .tx_busy(tx_busy), .sdo(sdo),
    .status(status_w)
);

// File: tb/serial_port_core_bench.sv
`timescale 1ns/1ps
// Bench: table-driven receive vectors, then directed tests.
module serial_port_core_bench;
    logic       clk = 1'b0, rst_n = 1'b0;
    logic       sel = 1'b0, addr = 1'b0, wr_stb = 1'b0, rd_stb = 1'b0;
    logic [7:0] wdata = '0, rdata;
    logic       sdi = 1'b1, cts = 1'b1, dsr = 1'b1;
    logic       sdo, rts, dtr, intr, baud_tick;
    int         n_chk = 0, n_bad = 0;

    always #5 clk = ~clk;

    serial_port_core u_serial_port_core (
        .clk(clk), .rst_n(rst_n), .sel(sel), .addr(addr), .wr_stb(wr_stb),
        .rd_stb(rd_stb), .wdata(wdata), .rdata(rdata), .sdi(sdi), .sdo(sdo),
        .cts(cts), .dsr(dsr), .rts(rts), .dtr(dtr), .intr(intr),
        .baud_tick(baud_tick)
    );

    // {stop bad, parity bad, odd, parity enable, data}
    localparam logic [11:0] VECS [7] = '{
        12'h0A5, 12'h13C, 12'h381, 12'h555, 12'h70F, 12'h8FF, 12'h912
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic report();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    endtask

    task automatic wr(input logic a, input logic [7:0] d);
        @(negedge clk); sel = 1; addr = a; wdata = d; wr_stb = 1;
        @(negedge clk); sel = 0; wr_stb = 0;
    endtask

    task automatic rd(input logic a, output logic [7:0] d);
        @(negedge clk); sel = 1; addr = a; rd_stb = 1; #1 d = rdata;
        @(negedge clk); sel = 0; rd_stb = 0;
    endtask

    task automatic peek(input logic a, output logic [7:0] d);
        addr = a; #1 d = rdata;
    endtask

    task automatic wait_ticks(input int n);
        for (int k = 0; k < n; ) begin
            @(negedge clk);
            if (baud_tick) k++;
        end
    endtask

    task automatic send_bit(input logic v);
        sdi = v; wait_ticks(16);
    endtask

    task automatic send_body(input logic [7:0] d, input logic pen, input logic podd, input logic flip);
        send_bit(1'b0);
        for (int i = 0; i < 8; i++) send_bit(d[i]);
        if (pen) send_bit((^d) ^ podd ^ flip);
    endtask

    task automatic send_full(input logic [7:0] d);
        send_body(d, 1'b0, 1'b0, 1'b0);
        send_bit(1'b1);
        wait_ticks(8);
    endtask

    task automatic period(output int p);
        p = 0;
        do @(negedge clk); while (!baud_tick);
        do begin @(negedge clk); p++; end while (!baud_tick);
    endtask

    initial begin
        #1_500_000;
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=hung expected=finished");
        report();
        $finish;
    end

    initial begin
        logic [7:0] s, d;
        int p, n, ticks_seen;
        logic [10:0] frame;

        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1 reset state
        peek(1, s); chk("R1 status", s, 8'h60);
        chk("R1 sdo", sdo, 1); chk("R1 rts/dtr", {rts, dtr}, 0); chk("R1 intr", intr, 0);
        ticks_seen = 0;
        for (int i = 0; i < 20; i++) begin @(negedge clk); if (baud_tick) ticks_seen++; end
        chk("R1 no tick before mode write", ticks_seen, 0);

        // R2 prescaler and divider
        wr(1, 8'h81); wr(1, 8'h01);
        period(p); period(p); chk("R2 ratio3 div2", p, 6);
        wr(1, 8'h02); period(p); period(p); chk("R2 ratio4 div2", p, 8);
        wr(1, 8'h03); period(p); period(p); chk("R2 ratio2 div2", p, 4);
        wr(1, 8'h80); wr(1, 8'h00); period(p); period(p); chk("R2 ratio1 div1", p, 1);

        // Table of receive vectors: R6, R8, R9
        for (int v = 0; v < 7; v++) begin
            logic sb, pb, po, pen;
            {sb, pb, po, pen} = VECS[v][11:8];
            wr(1, {3'b000, po, pen, 3'b000});
            send_body(VECS[v][7:0], pen, po, pb);
            sdi = !sb; wait_ticks(8);
            peek(1, s); chk("R8 data ready not before stop mid", s[7], 0);
            wait_ticks(8); sdi = 1; wait_ticks(8);
            chk("R13 intr with data ready", intr, 1);
            rd(1, s); chk("R9 status vector", s, 8'hE0 | {6'd0, sb, pb & pen});
            rd(0, d); chk("R6 received byte", d, VECS[v][7:0]);
            peek(1, s); chk("R8 read clears data ready", s[7], 0);
        end

        // R7 glitch on start
        wr(1, 8'h00);
        sdi = 0; wait_ticks(4); sdi = 1; wait_ticks(48);
        peek(1, s); chk("R7 glitch gives no char", s, 8'h60);
        send_full(8'h5A); rd(0, d); chk("R7 receiver recovers", d, 8'h5A);

        // R10 overrun, R12 status clear
        send_full(8'h11); send_full(8'h22);
        rd(1, s); chk("R10 overrun flagged", s, 8'hE4);
        rd(1, s); chk("R12 read clears errors only", s, 8'hE0);
        rd(0, d); chk("R10 newer byte kept", d, 8'h22);

        // R11 break
        sdi = 0; wait_ticks(16 * 11); sdi = 1; wait_ticks(16);
        rd(1, s); chk("R11 break and framing", s, 8'hEA);
        rd(0, d); chk("R11 break data", d, 8'h00);

        // R13 modem
        wr(1, 8'h60); chk("R13 rts/dtr", {rts, dtr}, 2'b11);
        dsr = 0; repeat (6) @(negedge clk);
        peek(1, s); chk("R13 modem change", s[4], 1); chk("R13 intr", intr, 1);
        rd(1, s); peek(1, s); chk("R12 modem flag cleared", s, 8'h60); chk("R13 intr low", intr, 0);

        // R3, R4 transmit with even parity
        wr(1, 8'h08);
        wr(0, 8'hB4);
        n = 0;
        for (int i = 0; i < 40; i++) begin
            peek(1, s);
            if (s[6]) break;
            if (baud_tick) n++;
            @(negedge clk);
        end
        chk("R4 ticks to buffer empty", n, 4);
        wait_ticks(8); frame[0] = sdo;
        for (int b = 1; b < 11; b++) begin
            wait_ticks(16); frame[b] = sdo;
            if (b == 5) begin peek(1, s); chk("R4 TC low while shifting", s[5], 0); end
        end
        chk("R3 frame bits", frame, {1'b1, ^8'hB4, 8'hB4, 1'b0});
        wait_ticks(16); peek(1, s); chk("R4 TC after frame", s[5], 1);

        // R14 clear-to-send gating
        cts = 0; repeat (4) @(negedge clk);
        rd(1, s);
        wr(0, 8'h3C); wait_ticks(40);
        peek(1, s); chk("R14 holding stays full", s[6], 0); chk("R14 line idle", sdo, 1);
        cts = 1; wait_ticks(10);
        peek(1, s); chk("R14 sends after cts", s[6], 1);
        wait_ticks(16 * 12); rd(1, s);

        // R5 echo
        wr(1, 8'h04);
        wr(0, 8'h33); repeat (10) @(negedge clk);
        peek(1, s); chk("R5 write ignored", s[6], 1);
        sdi = 0; #1 chk("R5 echo low", sdo, 0);
        sdi = 1; #1 chk("R5 echo high", sdo, 1);

        report();
        $finish;
    end
endmodule